// File: doc/BRIEF.md
# Multiplexed 8-bit Host Bus Read Port

This block is the slave end of a multiplexed address/data bus for an 8-bit host. The host first puts a register address on the shared AD lines and pulses an address-latch strobe. It then pulls its read strobe and chip select low. While that access is qualified, the block drives the selected register byte on the low data lane and raises a tristate enable for the pad ring. All bus inputs pass through a shared synchronizer into the internal clock domain. Edges are detected there.

The latched address is kept until the next address-latch strobe. A host can therefore read the same register again without a new address phase. The byte for an access is fetched from an external register-file read port once, when the access begins, and is held for the rest of that access. An address beyond the implemented register count reads as zero. The block never drives the bus while the write strobe is low, or while any of the three upper byte enables is low.

Top module: `mbr_host_rd_if`

## Requirements
- R1: After reset the data enable `bus_doe_o` is 0 and `bus_dout_o` is 0x00. The latched address is 0 and the bus starts in tristate.
- R2: On the falling edge of `bus_ale_i`, the block captures the AD value that was present while `bus_ale_i` was high. That address is kept until the next falling edge, so repeated reads with no address phase return the same register.
- R3: An access is active only when the OR of `bus_rd_n_i` and `bus_cs_n_i` is 0, which means both are low. `bus_doe_o` rises on the third rising clock edge after the strobes go low. With only one of the two low, it stays 0.
- R4: If any of `bus_be_n_i[3:1]` is 0, `bus_doe_o` is 0. This also holds when such a bit falls in the middle of an access.
- R5: The low lane drives only if `bus_be_n_i[0]` is 0 during the access, or if it was 0 when the address was latched.
- R6: While `bus_wr_n_i` is 0, `bus_doe_o` stays 0.
- R7: `bus_dout_o` takes the register value at the clock where the access begins. It stays stable while `bus_doe_o` is high, even if the register changes.
- R8: An address of `NUM_REGS` (16) or above reads as 0x00. Address `NUM_REGS`-1 reads its register.
- R9: `bus_doe_o` returns to 0 on the third rising edge after the access ends.
- R10: If the address-latch falling edge and the access start are seen in the same clock, the data comes from the newly latched address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad_i | input | ADDR_W (8) | Address part of the multiplexed AD lines |
| bus_ale_i | input | 1 | Address-latch strobe, address taken when it falls |
| bus_rd_n_i | input | 1 | Active-low read strobe |
| bus_cs_n_i | input | 1 | Active-low chip select |
| bus_wr_n_i | input | 1 | Active-low write strobe, must stay high for reads |
| bus_be_n_i | input | 4 | Active-low byte enables, bit 0 is the low lane |
| bus_dout_o | output | 8 | Read byte for the low data lane |
| bus_doe_o | output | 1 | Output enable for the low data lane pads |
| rf_addr_o | output | RF_AW (4) | Register-file read address |
| rf_rdata_i | input | 8 | Register-file read data, combinational |

## Verification
The address latch and the read-data fetch can act in the same clock. This happens when the host releases the address-latch strobe on the same edge at which it lowers read and select. The bench creates this case by changing all three inputs at one instant after a different address was latched earlier. The check passes only if the driven byte belongs to the new address, which shows that the fetch used the bypassed address and not the stale one.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  localparam int BE_W = 4;

  typedef struct packed {
    logic            ale;
    logic            rd_n;
    logic            cs_n;
    logic            wr_n;
    logic [BE_W-1:0] be_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ale: 1'b0, rd_n: 1'b1, cs_n: 1'b1,
                                wr_n: 1'b1, be_n: {BE_W{1'b1}}};

  // combined strobe: active when the OR of the two lows is low
  function automatic logic strobe_on(logic rd_n, logic cs_n);
    return ~(rd_n | cs_n);
  endfunction

  // upper lanes must be high; low lane enabled now or at latch time
  function automatic logic lanes_ok(logic [BE_W-1:0] be_n, logic be0_lat_n);
    return (&be_n[BE_W-1:1]) && (!be_n[0] || !be0_lat_n);
  endfunction

  function automatic logic reg_hit(logic [31:0] addr, int unsigned nregs);
    return addr < nregs;
  endfunction

endpackage

// File: rtl/mbr_sync.sv
module mbr_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= RST;
        else        pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= RST;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/mbr_addr_latch.sv
module mbr_addr_latch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_ale,
  input  logic [ADDR_W-1:0] s_ad,
  input  logic              s_be0_n,
  output logic              ale_fall,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [ADDR_W-1:0] addr_q,
  output logic              be0_nxt
);

  logic              ale_d;
  logic [ADDR_W-1:0] ad_d;
  logic              be0_d;
  logic              be0_q;

  // ad_d / be0_d hold the values seen while the strobe was still high
  assign ale_fall = ale_d & ~s_ale;
  assign addr_nxt = ale_fall ? ad_d  : addr_q;
  assign be0_nxt  = ale_fall ? be0_d : be0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d  <= 1'b0;
      ad_d   <= '0;
      be0_d  <= 1'b1;
      addr_q <= '0;
      be0_q  <= 1'b1;
    end else begin
      ale_d  <= s_ale;
      ad_d   <= s_ad;
      be0_d  <= s_be0_n;
      addr_q <= addr_nxt;
      be0_q  <= be0_nxt;
    end
  end

endmodule

// File: rtl/mbr_read_path.sv
module mbr_read_path
  import mbr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_on,
  input  logic              drive_ok,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic [7:0]        rf_rdata,
  output logic [7:0]        dout,
  output logic              doe
);

  logic acc_d;
  logic acc_start;
  logic hit;

  assign acc_start = acc_on & ~acc_d;
  assign hit       = reg_hit(32'(addr_nxt), NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_d <= 1'b0;
      dout  <= 8'h00;
      doe   <= 1'b0;
    end else begin
      acc_d <= acc_on;
      if (acc_start) dout <= hit ? rf_rdata : 8'h00;
      doe   <= acc_on & drive_ok;
    end
  end

endmodule

// File: rtl/mbr_host_rd_if.sv
module mbr_host_rd_if
  import mbr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int RF_AW      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_ad_i,
  input  logic              bus_ale_i,
  input  logic              bus_rd_n_i,
  input  logic              bus_cs_n_i,
  input  logic              bus_wr_n_i,
  input  logic [BE_W-1:0]   bus_be_n_i,
  output logic [7:0]        bus_dout_o,
  output logic              bus_doe_o,
  output logic [RF_AW-1:0]  rf_addr_o,
  input  logic [7:0]        rf_rdata_i
);

  localparam int              SYNC_W   = $bits(ctl_t) + ADDR_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {CTL_IDLE, {ADDR_W{1'b0}}};

  logic [SYNC_W-1:0] raw_bus;
  logic [SYNC_W-1:0] s_bus;
  ctl_t              s_ctl;
  logic [ADDR_W-1:0] s_ad;

  // named internal events, also observed by the checker
  logic              acc_on;
  logic              lane_ok;
  logic              wr_ok;
  logic              drive_ok;
  logic              ale_fall;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic              be0_nxt;

  assign raw_bus = {bus_ale_i, bus_rd_n_i, bus_cs_n_i, bus_wr_n_i,
                    bus_be_n_i, bus_ad_i};

  mbr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (s_bus)
  );

  assign {s_ctl, s_ad} = s_bus;

  mbr_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_ale    (s_ctl.ale),
    .s_ad     (s_ad),
    .s_be0_n  (s_ctl.be_n[0]),
    .ale_fall (ale_fall),
    .addr_nxt (addr_nxt),
    .addr_q   (addr_q),
    .be0_nxt  (be0_nxt)
  );

  assign acc_on   = strobe_on(s_ctl.rd_n, s_ctl.cs_n);
  assign lane_ok  = lanes_ok(s_ctl.be_n, be0_nxt);
  assign wr_ok    = s_ctl.wr_n;
  assign drive_ok = lane_ok & wr_ok;

  assign rf_addr_o = addr_nxt[RF_AW-1:0];

  mbr_read_path #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_on   (acc_on),
    .drive_ok (drive_ok),
    .addr_nxt (addr_nxt),
    .rf_rdata (rf_rdata_i),
    .dout     (bus_dout_o),
    .doe      (bus_doe_o)
  );

endmodule

// File: rtl/mbr_host_rd_if_chk.sv
module mbr_host_rd_if_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_on,
  input logic              lane_ok,
  input logic              wr_ok,
  input logic              ale_fall,
  input logic [ADDR_W-1:0] addr_q,
  input logic [7:0]        data_o,
  input logic              oe
);

  a_r3_drive_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $past(acc_on));

  // R4 and R5: lane qualification
  a_r4_lanes_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $past(lane_ok));

  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $past(wr_ok));

  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe)) |-> $stable(data_o));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_on |=> !oe);

  a_r2_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(addr_q));

endmodule

bind mbr_host_rd_if mbr_host_rd_if_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_on   (acc_on),
  .lane_ok  (lane_ok),
  .wr_ok    (wr_ok),
  .ale_fall (ale_fall),
  .addr_q   (addr_q),
  .data_o   (bus_dout_o),
  .oe       (bus_doe_o)
);

// File: tb/tb_mbr_host_rd_if.sv
module tb_mbr_host_rd_if;

  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ad = 8'h00;
  logic       ale = 1'b0, rd_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1;
  logic [3:0] be_n = 4'b1110;
  logic [7:0] dout;
  logic       doe;
  logic [3:0] rf_addr;
  logic [7:0] rf_rdata;
  logic [7:0] regs [NREG];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic       oe;
    logic       chk_data;
    logic [7:0] data;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  assign rf_rdata = regs[rf_addr];

  mbr_host_rd_if dut (
    .clk(clk), .rst_n(rst_n), .bus_ad_i(ad), .bus_ale_i(ale),
    .bus_rd_n_i(rd_n), .bus_cs_n_i(cs_n), .bus_wr_n_i(wr_n),
    .bus_be_n_i(be_n), .bus_dout_o(dout), .bus_doe_o(doe),
    .rf_addr_o(rf_addr), .rf_rdata_i(rf_rdata)
  );

  // monitor: pops expectations and compares the outputs
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      n_chk++;
      if (doe !== it.oe || (it.chk_data && dout !== it.data)) begin
        n_fail++;
        $display("FAIL %s: oe=%0b exp %0b data=%02h exp %02h",
                 it.tag, doe, it.oe, dout, it.data);
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, exp completion");
      report();
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string tag, logic oe, logic chk, logic [7:0] d);
    item_t it;
    it.tag = tag; it.oe = oe; it.chk_data = chk; it.data = d;
    sb_q.push_back(it);
    #1;
  endtask

  function automatic logic [7:0] model(logic [7:0] a);
    return (a < NREG) ? regs[a[3:0]] : 8'h00;
  endfunction

  task automatic addr_phase(logic [7:0] a, logic be0n);
    ad = a; ale = 1'b1; be_n = {3'b111, be0n};
    cyc(3);
    ale = 1'b0; ad = 8'hEE;
    cyc(3);
  endtask

  task automatic strobe(bit on);
    rd_n = !on; cs_n = !on;
  endtask

  initial begin
    logic [7:0] e;
    for (int i = 0; i < NREG; i++) regs[i] = 8'(i * 37) ^ 8'h5A;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_out("R1 reset state", 1'b0, 1'b1, 8'h00);

    // R2/R3/R7/R9 basic read of register 3
    addr_phase(8'h03, 1'b0);
    e = regs[3];
    strobe(1);
    cyc(2); expect_out("R3 latency not yet", 1'b0, 1'b0, 8'h00);
    cyc(1); expect_out("R2 read reg3", 1'b1, 1'b1, e);
    regs[3] = 8'hC3;
    cyc(2); expect_out("R7 data held", 1'b1, 1'b1, e);
    cs_n = 1'b1;
    cyc(2); expect_out("R9 still driving", 1'b1, 1'b1, e);
    cyc(1); expect_out("R9 released", 1'b0, 1'b0, 8'h00);
    rd_n = 1'b1; cyc(3);

    // R2 reuse of latched address
    strobe(1); cyc(4);
    expect_out("R2 reread no address phase", 1'b1, 1'b1, 8'hC3);
    strobe(0); cyc(4);

    // R3 single strobe low
    rd_n = 1'b0; cyc(5); expect_out("R3 rd only", 1'b0, 1'b0, 8'h00);
    rd_n = 1'b1; cs_n = 1'b0; cyc(5); expect_out("R3 cs only", 1'b0, 1'b0, 8'h00);
    cs_n = 1'b1; cyc(3);

    // R4 upper byte enables
    for (int j = 1; j < 4; j++) begin
      be_n = 4'b1110; be_n[j] = 1'b0;
      strobe(1); cyc(5);
      expect_out("R4 upper lane low", 1'b0, 1'b0, 8'h00);
      strobe(0); be_n = 4'b1110; cyc(3);
    end
    strobe(1); cyc(4); expect_out("R4 lanes ok", 1'b1, 1'b1, 8'hC3);
    be_n[2] = 1'b0; cyc(3); expect_out("R4 mid-access drop", 1'b0, 1'b0, 8'h00);
    strobe(0); be_n = 4'b1110; cyc(4);

    // R5 low lane
    addr_phase(8'h03, 1'b1);
    be_n = 4'b1111; strobe(1); cyc(5);
    expect_out("R5 be0 high both times", 1'b0, 1'b0, 8'h00);
    strobe(0); cyc(4);
    be_n = 4'b1110; strobe(1); cyc(4);
    expect_out("R5 be0 low at access", 1'b1, 1'b1, 8'hC3);
    strobe(0); cyc(4);
    addr_phase(8'h05, 1'b0);
    be_n = 4'b1111; strobe(1); cyc(4);
    expect_out("R5 be0 low at latch", 1'b1, 1'b1, model(8'h05));
    strobe(0); be_n = 4'b1110; cyc(4);

    // R6 write strobe low
    wr_n = 1'b0; strobe(1); cyc(5);
    expect_out("R6 write low", 1'b0, 1'b0, 8'h00);
    strobe(0); wr_n = 1'b1; cyc(4);

    // R8 decode boundary
    addr_phase(8'h20, 1'b0); strobe(1); cyc(4);
    expect_out("R8 unimplemented 0x20", 1'b1, 1'b1, 8'h00);
    strobe(0); cyc(4);
    addr_phase(8'h10, 1'b0); strobe(1); cyc(4);
    expect_out("R8 unimplemented 0x10", 1'b1, 1'b1, 8'h00);
    strobe(0); cyc(4);
    addr_phase(8'h0F, 1'b0); strobe(1); cyc(4);
    expect_out("R8 last register", 1'b1, 1'b1, model(8'h0F));
    strobe(0); cyc(4);

    // R10 latch fall and access start in the same clock
    ad = 8'h07; ale = 1'b1; cyc(3);
    ale = 1'b0; ad = 8'hEE; strobe(1);
    cyc(3);
    expect_out("R10 same-cycle latch and fetch", 1'b1, 1'b1, model(8'h07));
    strobe(0); cyc(4);

    wait (sb_q.size() == 0);
    #1;
    done = 1;
    report();
    $finish;
  end

endmodule